// File: doc/BRIEF.md
# NAND Command Word Sequencer

This block turns a host request into one NAND operation. The host gives an opcode, an optional column, an optional page address, a chip choice, the page-size class of the device and whether the device has more than 65536 pages. From these the block builds a 32-bit control word. The word records the direction of the data phase, the number of address cycles and the chosen chip. The block also decides whether a second opcode must follow the address bytes, and how many data bytes the operation moves.

Program setup and erase setup only start a two-phase operation. The block keeps their control word and waits. The later confirm opcode is queued as the second opcode, and the kept word then runs. Once a command starts, a simple NAND bus steps through these phases in order: command latch, address latch, an optional second command latch, a wait for the ready line, and the data strobes. The block then sets a completion flag, which the host clears by writing a one to it.

Top module: `nand_cmd_seq`

## Requirements
- R1: The control word carries command-valid in bit 31 and the issued opcode in bits 7:0. Bit 26 marks a read-data phase and bit 25 a write-data phase (program setup 0x80 only). Bit 19 is set when chip 1 is selected.
- R2: A column adds 2 address cycles. A page address adds 2 more, plus 1 when the device has more than 65536 pages. Bits 30:27 hold (cycles-1) with bit 30 forced to 1, or zero when there are no address cycles. Exactly that many address-latch cycles appear on the bus.
- R3: READ ID (0x90) and STATUS (0x70) run as reads with exactly one address cycle (field 0b1000) and a data length of 4. The single address byte is the low byte of the column, or zero when no column is given.
- R4: Program setup (0x80) and erase setup (0x60) store their control word, shown on `ctrl_word`, and cause no bus activity. For program setup the data length is taken from `wr_len`. For erase setup it is zero.
- R5: A confirm opcode (0x10 or 0xD0) that follows a stored setup sets the second-opcode register to 0x100|opcode. It then runs the stored word: the setup opcode, the stored address bytes, then the confirm opcode.
- R6: On large-page devices READ0 (0x00) queues 0x130 as the second opcode. Random data out (0x05) always queues 0x1E0. Every other command clears the second-opcode register to 0.
- R7: On large-page devices a spare-area read (0x50) is issued as opcode 0x00, with the column increased by the page data size (2048). The first two address bytes are that column, low byte first.
- R8: For READ0, READ1, spare read and random data out, the data length is the page data size plus the spare size minus the column: 2048+64 for large pages, 512+16 for small ones. The data-length output shows the byte count itself, and the data phase gives exactly that many read or write strobes.
- R9: When the data phase ends, interrupt bit 31 (command done) is set. A read started with `dma_en` high sets bit 28 (DMA done) instead. Writing a 1 to either bit clears it.
- R10: Status bit 30 follows the device ready line. The engine stays in its wait phase, with no data strobes, while the ready line is low.
- R11: A request that arrives while an operation is in progress is ignored. It sets a sticky error flag that only reset clears.
- R12: The bus phases run in this order: one command-latch cycle, the address cycles, an optional second command-latch cycle, at least one wait cycle, the data strobes, and one completion cycle. Only the chosen chip-enable is driven low, and only while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle command request |
| opcode | input | 8 | NAND opcode of the request |
| col_vld | input | 1 | Column supplied |
| col | input | COL_W | Column address |
| page_vld | input | 1 | Page address supplied |
| page | input | PAGE_W | Page address |
| chip_sel | input | 1 | Selects chip 1 when high |
| large_page | input | 1 | Device has large (2048-byte) pages |
| big_dev | input | 1 | Device has more than 65536 pages |
| dma_en | input | 1 | Reads complete through DMA done |
| wr_len | input | LEN_W | Byte count for program data |
| rb_n | input | 1 | Device ready line (high = ready) |
| irq_we | input | 1 | Interrupt write strobe |
| irq_wdata | input | 32 | Write-one-to-clear mask |
| ctrl_word | output | 32 | Current or stored control word |
| cmd2_reg | output | 9 | Second opcode register, bit 8 = enable |
| data_len | output | LEN_W | Data length register |
| irq_status | output | 32 | Bit 31 command done, bit 28 DMA done |
| stat_word | output | 32 | Status, bit 30 = device ready |
| busy | output | 1 | Operation in progress |
| err_busy | output | 1 | Sticky flag for a request dropped while busy |
| bus_cle | output | 1 | Command latch enable |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_io | output | 8 | Byte driven in command and address phases |
| bus_ce_n | output | 2 | Active-low chip enables |

## Verification
The control word, the second-opcode register and the data length are registered on the clock edge that samples the request. They are checked one half-cycle later. The bench then samples the bus at each falling edge until `busy` drops. At that point the completion flag has been set by the edge that left the completion cycle. For each operation it checks that the busy time equals address cycles plus command-latch cycles plus data length plus two, with the ready line held high. The wait-phase tests hold the ready line low for a fixed number of cycles and check that no strobe appears meanwhile.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int COL_W    = 16,
  parameter int PAGE_W   = 24,
  parameter int LEN_W    = 16,
  parameter int LP_BYTES = 2048,
  parameter int LP_SPARE = 64,
  parameter int SP_BYTES = 512,
  parameter int SP_SPARE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [7:0]        opcode,
  input  logic              col_vld,
  input  logic [COL_W-1:0]  col,
  input  logic              page_vld,
  input  logic [PAGE_W-1:0] page,
  input  logic              chip_sel,
  input  logic              large_page,
  input  logic              big_dev,
  input  logic              dma_en,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              rb_n,
  input  logic              irq_we,
  input  logic [31:0]       irq_wdata,
  output logic [31:0]       ctrl_word,
  output logic [8:0]        cmd2_reg,
  output logic [LEN_W-1:0]  data_len,
  output logic [31:0]       irq_status,
  output logic [31:0]       stat_word,
  output logic              busy,
  output logic              err_busy,
  output logic              bus_cle,
  output logic              bus_ale,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_io,
  output logic [1:0]        bus_ce_n
);
  localparam int AW = COL_W + PAGE_W;
  localparam logic [LEN_W-1:0] LP_TOT = LEN_W'(LP_BYTES + LP_SPARE);
  localparam logic [LEN_W-1:0] SP_TOT = LEN_W'(SP_BYTES + SP_SPARE);

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAIT, S_DATA, S_DONE} st_t;
  st_t st;

  logic [31:0]      ctrl_q;
  logic [8:0]       cmd2_q;
  logic [LEN_W-1:0] len_q, dcnt;
  logic [AW-1:0]    addr_q;
  logic [2:0]       acnt;
  logic             held_q, dma_q, done_f, dmad_f, err_q;

  wire is_oob  = large_page && opcode == 8'h50;
  wire [7:0] op_e = is_oob ? 8'h00 : opcode;
  wire is_id   = opcode == 8'h90 || opcode == 8'h70;
  wire is_pgrd = opcode == 8'h00 || opcode == 8'h01 || opcode == 8'h50 || opcode == 8'h05;
  wire is_rd   = is_id || is_pgrd;
  wire is_wr   = opcode == 8'h80;
  wire is_setup = is_wr || opcode == 8'h60;
  wire is_conf = opcode == 8'h10 || opcode == 8'hD0;
  wire col_p   = col_vld || is_oob;
  wire [COL_W-1:0] col_e = (col_vld ? col : '0) + (is_oob ? COL_W'(LP_BYTES) : '0);

  wire [2:0] n_norm = (col_p ? 3'd2 : 3'd0) + (page_vld ? 3'd2 + {2'b0, big_dev} : 3'd0);
  wire [2:0] n_cyc  = is_id ? 3'd1 : n_norm;
  wire [3:0] afield = (n_cyc == 3'd0) ? 4'd0 : (({1'b0, n_cyc} - 4'd1) | 4'd8);
  wire [31:0] word_n = {1'b1, afield, is_rd, is_wr, 5'b0, chip_sel, 11'b0, op_e};

  wire [LEN_W-1:0] ptot = large_page ? LP_TOT : SP_TOT;
  wire [LEN_W-1:0] len_n = is_id ? LEN_W'(4) : is_pgrd ? ptot - LEN_W'(col_e) :
                           is_wr ? wr_len : '0;
  wire [AW-1:0] addr_n = is_id ? AW'(col_e[7:0]) :
                         col_p ? {page, col_e} : AW'(page);
  wire [8:0] cmd2_n = (opcode == 8'h05) ? 9'h1E0 :
                      (op_e == 8'h00 && is_pgrd && large_page) ? 9'h130 : 9'h000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctrl_q <= '0; cmd2_q <= '0; len_q <= '0; dcnt <= '0;
      addr_q <= '0; acnt <= '0; held_q <= 1'b0; dma_q <= 1'b0;
      done_f <= 1'b0; dmad_f <= 1'b0; err_q <= 1'b0;
    end else begin
      if (irq_we) begin
        if (irq_wdata[31]) done_f <= 1'b0;
        if (irq_wdata[28]) dmad_f <= 1'b0;
      end
      if (req && st != S_IDLE) err_q <= 1'b1;
      unique case (st)
        S_IDLE: if (req) begin
          dma_q <= dma_en;
          if (is_conf && held_q) begin
            cmd2_q <= {1'b1, opcode};
            held_q <= 1'b0;
            st     <= S_CMD1;
          end else begin
            ctrl_q <= word_n; len_q <= len_n; addr_q <= addr_n;
            cmd2_q <= cmd2_n;
            held_q <= is_setup;
            if (!is_setup) st <= S_CMD1;
          end
        end
        S_CMD1: begin
          acnt <= ctrl_q[29:27];
          st   <= ctrl_q[30] ? S_ADDR : (cmd2_q[8] ? S_CMD2 : S_WAIT);
        end
        S_ADDR: begin
          addr_q <= addr_q >> 8;
          if (acnt == 3'd0) st <= cmd2_q[8] ? S_CMD2 : S_WAIT;
          else acnt <= acnt - 3'd1;
        end
        S_CMD2: st <= S_WAIT;
        S_WAIT: if (rb_n) begin
          dcnt <= len_q - LEN_W'(1);
          st   <= (len_q != '0) ? S_DATA : S_DONE;
        end
        S_DATA: begin
          dcnt <= dcnt - LEN_W'(1);
          if (dcnt == '0) st <= S_DONE;
        end
        S_DONE: begin
          if (ctrl_q[26] && dma_q) dmad_f <= 1'b1;
          else done_f <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctrl_word  = ctrl_q;
  assign cmd2_reg   = cmd2_q;
  assign data_len   = len_q;
  assign irq_status = {done_f, 2'b0, dmad_f, 28'b0};
  assign stat_word  = {1'b0, rb_n, 30'b0};
  assign busy       = st != S_IDLE;
  assign err_busy   = err_q;
  assign bus_cle    = st == S_CMD1 || st == S_CMD2;
  assign bus_ale    = st == S_ADDR;
  assign bus_rd     = st == S_DATA && ctrl_q[26];
  assign bus_wr     = st == S_DATA && ctrl_q[25];
  assign bus_io     = (st == S_CMD1) ? ctrl_q[7:0] : (st == S_CMD2) ? cmd2_q[7:0] :
                      (st == S_ADDR) ? addr_q[7:0] : 8'h00;
  assign bus_ce_n   = !busy ? 2'b11 : (ctrl_q[19] ? 2'b01 : 2'b10);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && st != S_IDLE |=> err_busy);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |=> err_busy);
  // R4
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && st == S_IDLE && (opcode == 8'h80 || opcode == 8'h60) |=> !busy);
  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && !rb_n |=> st == S_WAIT && !bus_rd && !bus_wr);
  // R12
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_cle, bus_ale, bus_rd, bus_wr}));
  // R12
  ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n != 2'b00);
  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DONE && !(ctrl_q[26] && dma_q) |=> irq_status[31]);
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_we && irq_wdata[31] && st != S_DONE |=> !irq_status[31]);
  // R1
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_word[26] && ctrl_word[25]));
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb_top;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic rst_n, req, col_vld, page_vld, chip_sel, large_page, big_dev, dma_en, rb_n, irq_we;
  logic [7:0] opcode;
  logic [15:0] col, wr_len;
  logic [23:0] page;
  logic [31:0] irq_wdata;
  logic [31:0] ctrl_word, irq_status, stat_word;
  logic [8:0] cmd2_reg;
  logic [15:0] data_len;
  logic busy, err_busy, bus_cle, bus_ale, bus_rd, bus_wr;
  logic [7:0] bus_io;
  logic [1:0] bus_ce_n;

  nand_cmd_seq dut_i (.clk, .rst_n, .req, .opcode, .col_vld, .col, .page_vld, .page,
    .chip_sel, .large_page, .big_dev, .dma_en, .wr_len, .rb_n, .irq_we, .irq_wdata,
    .ctrl_word, .cmd2_reg, .data_len, .irq_status, .stat_word, .busy, .err_busy,
    .bus_cle, .bus_ale, .bus_rd, .bus_wr, .bus_io, .bus_ce_n);

  typedef struct packed {
    logic [7:0] op; logic colv; logic [15:0] cl; logic pgv; logic [23:0] pg;
    logic lg; logic bg; logic dm; logic cs;
    logic [31:0] ectrl; logic [15:0] elen; logic [8:0] ecmd2;
    logic [2:0] eale; logic [1:0] ecle; logic [15:0] ea16; logic eb28;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{8'h00,1'b1,16'h0000,1'b1,24'h000123,1'b1,1'b0,1'b0,1'b0,32'hDC000000,16'd2112,9'h130,3'd4,2'd2,16'h0000,1'b0},
    '{8'h50,1'b1,16'h0000,1'b1,24'h000010,1'b1,1'b1,1'b1,1'b1,32'hE4080000,16'd64,  9'h130,3'd5,2'd2,16'h0800,1'b1},
    '{8'h90,1'b1,16'h0000,1'b0,24'h000000,1'b0,1'b0,1'b0,1'b0,32'hC4000090,16'd4,   9'h000,3'd1,2'd1,16'h0000,1'b0}, // R3
    '{8'h70,1'b0,16'h0000,1'b0,24'h000000,1'b1,1'b0,1'b1,1'b0,32'hC4000070,16'd4,   9'h000,3'd1,2'd1,16'h0000,1'b1}, // R3
    '{8'h00,1'b1,16'h0010,1'b1,24'h000005,1'b0,1'b0,1'b0,1'b0,32'hDC000000,16'd512, 9'h000,3'd4,2'd1,16'h0010,1'b0},
    '{8'h05,1'b1,16'h0020,1'b0,24'h000000,1'b1,1'b0,1'b0,1'b0,32'hCC000005,16'd2080,9'h1E0,3'd2,2'd2,16'h0020,1'b0},
    '{8'hFF,1'b0,16'h0000,1'b0,24'h000000,1'b1,1'b0,1'b0,1'b0,32'h800000FF,16'd0,   9'h000,3'd0,2'd1,16'h0000,1'b0}
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] op, input logic cv, input logic [15:0] c,
                        input logic pv, input logic [23:0] p, input logic lg, input logic bg,
                        input logic dm, input logic cs, input logic [15:0] wl);
    @(negedge clk);
    opcode = op; col_vld = cv; col = c; page_vld = pv; page = p;
    large_page = lg; big_dev = bg; dma_en = dm; chip_sel = cs; wr_len = wl; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic clr_irq();
    irq_we = 1'b1; irq_wdata = 32'h9000_0000;
    @(negedge clk);
    irq_we = 1'b0; irq_wdata = '0;
  endtask

  task automatic observe(input logic [31:0] ectrl, input logic [15:0] elen,
                         input logic [8:0] ecmd2, input int eale, input int ecle,
                         input logic [15:0] ea16, input logic eb28);
    int ale = 0, cle = 0, nrd = 0, nwr = 0, cyc = 0;
    logic [7:0] ab [2];
    logic [7:0] cb [2];
    ab[0] = 8'h00; ab[1] = 8'h00; cb[0] = 8'h00; cb[1] = 8'h00;
    chk("R1 control word", ctrl_word, ectrl);
    chk("R8 data length", 32'(data_len), 32'(elen));
    chk("R6 second opcode", 32'(cmd2_reg), 32'(ecmd2));
    chk("R12 chip enable", 32'(bus_ce_n), ectrl[19] ? 32'd1 : 32'd2);
    while (busy && cyc < 5000) begin
      if (bus_ale) begin if (ale < 2) ab[ale] = bus_io; ale++; end
      if (bus_cle) begin if (cle < 2) cb[cle] = bus_io; cle++; end
      if (bus_rd) nrd++;
      if (bus_wr) nwr++;
      cyc++;
      @(negedge clk);
    end
    chk("R2 address cycles", 32'(ale), 32'(eale));
    chk("R12 command latches", 32'(cle), 32'(ecle));
    chk("R12 first command byte", 32'(cb[0]), 32'(ectrl[7:0]));
    if (ecle == 2) chk("R5 second command byte", 32'(cb[1]), 32'(ecmd2[7:0]));
    if (eale >= 2) chk("R7 column bytes", 32'({ab[1], ab[0]}), 32'(ea16));
    else if (eale == 1) chk("R3 single address byte", 32'(ab[0]), 32'(ea16[7:0]));
    chk("R8 read strobes", 32'(nrd), ectrl[26] ? 32'(elen) : 32'd0);
    chk("R8 write strobes", 32'(nwr), ectrl[25] ? 32'(elen) : 32'd0);
    chk("R12 busy cycles", 32'(cyc), 32'(eale + ecle + int'(elen) + 2));
    chk("R9 command done", 32'(irq_status[31]), 32'(!eb28));
    chk("R9 dma done", 32'(irq_status[28]), 32'(eb28));
    clr_irq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; opcode = '0; col_vld = 0; col = '0; page_vld = 0; page = '0;
    chip_sel = 0; large_page = 1; big_dev = 0; dma_en = 0; wr_len = '0; rb_n = 1'b1;
    irq_we = 0; irq_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 32'(busy), 0);
    chk("R1 reset control word", ctrl_word, 0);
    chk("R9 reset irq", irq_status, 0);
    chk("R11 reset error", 32'(err_busy), 0);
    chk("R12 reset chip enables", 32'(bus_ce_n), 3);
    chk("R10 status ready", stat_word, 32'h4000_0000);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      do_req(VT[i].op, VT[i].colv, VT[i].cl, VT[i].pgv, VT[i].pg, VT[i].lg, VT[i].bg,
             VT[i].dm, VT[i].cs, 16'd0);
      observe(VT[i].ectrl, VT[i].elen, VT[i].ecmd2, int'(VT[i].eale), int'(VT[i].ecle),
              VT[i].ea16, VT[i].eb28);
    end

    // R4 program setup held, R5 confirm merges
    do_req(8'h80, 1, 16'h0, 1, 24'h7, 1, 0, 1, 1, 16'd8);
    chk("R4 setup not started", 32'(busy), 0);
    chk("R4 setup stored word", ctrl_word, 32'hDA080080);
    chk("R4 no bus activity", 32'(bus_ce_n), 3);
    @(negedge clk);
    chk("R4 still idle", 32'(busy), 0);
    do_req(8'h10, 0, 16'h0, 0, 24'h0, 1, 0, 1, 0, 16'd0);
    observe(32'hDA080080, 16'd8, 9'h110, 4, 2, 16'h0000, 1'b0);

    // R4 erase setup, R5 confirm
    do_req(8'h60, 0, 16'h0, 1, 24'h200, 1, 1, 0, 0, 16'd0);
    chk("R4 erase stored word", ctrl_word, 32'hD0000060);
    chk("R4 erase not started", 32'(busy), 0);
    do_req(8'hD0, 0, 16'h0, 0, 24'h0, 1, 0, 0, 0, 16'd0);
    observe(32'hD0000060, 16'd0, 9'h1D0, 3, 2, 16'h0200, 1'b0);

    // R10 wait phase holds on low ready line
    rb_n = 1'b0;
    do_req(8'h70, 0, 16'h0, 0, 24'h0, 1, 0, 0, 0, 16'd0);
    begin
      int strobes = 0;
      for (int k = 0; k < 12; k++) begin
        if (bus_rd || bus_wr) strobes++;
        @(negedge clk);
      end
      chk("R10 busy while not ready", 32'(busy), 1);
      chk("R10 no strobes while not ready", 32'(strobes), 0);
      chk("R10 status not ready", stat_word, 32'h0);
    end

    // R11 request while busy is dropped
    do_req(8'h90, 1, 16'h55, 0, 24'h0, 1, 0, 0, 0, 16'd0);
    chk("R11 error flag", 32'(err_busy), 1);
    chk("R11 word unchanged", ctrl_word, 32'hC4000070);
    rb_n = 1'b1;
    for (int k = 0; k < 20 && busy; k++) @(negedge clk);
    chk("R11 error sticky", 32'(err_busy), 1);
    chk("R10 status ready again", stat_word, 32'h4000_0000);
    chk("R9 done after wait", 32'(irq_status[31]), 1);

    // R9 write-one-to-clear only touches written bits
    irq_we = 1'b1; irq_wdata = 32'h1000_0000;
    @(negedge clk);
    irq_we = 1'b0;
    chk("R9 unwritten bit kept", 32'(irq_status[31]), 1);
    irq_we = 1'b1; irq_wdata = 32'h8000_0000;
    @(negedge clk);
    irq_we = 1'b0;
    chk("R9 written bit cleared", 32'(irq_status[31]), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule